// File: doc/BRIEF.md
# Multichannel ADC Acquisition Sequencer

This block controls a 16-input ADC front end through a small byte-wide register set. Software chooses where conversions are triggered from: a register write, a pacer strobe or an external strobe. It also chooses whether every conversion uses one fixed channel, or whether the multiplexer sweeps upward from channel 0 to a programmed last channel and then wraps.

Each trigger raises a one-cycle conversion request toward the converter, together with the channel and the input range. The converter answers with a done strobe and a 16-bit result. Results collect in a 1024-entry sample FIFO. Software drains the FIFO by reading the data address.

A status byte reports the range setting and four active-low flags: FIFO empty, FIFO half-full, FIFO full and converter busy. Two local interrupt requests can each be pointed at one of two causes, and one register write clears them.

Top module: `acq_sequencer`

## Requirements
- R1: After synchronous reset, the status byte (address 2) reads 8'hE0, the mode register (address 3) reads 0, no conversion is requested and both interrupt requests are low. In that state the trigger source is software, autoscan is off and the FIFO is empty.
- R2: The mode register at address 3 keeps the low four bits of a write and reads them back in bits 3..0, with the upper bits reading 0. The bits are: bit 0 autoscan, bit 1 pacer trigger, bit 2 external trigger, bit 3 pretrigger.
- R3: With autoscan on, the channel register (address 1) holds the last channel. Successive conversions use channels 0, 1, … up to that value and then wrap to 0. A write to address 1 or address 3 restarts the sweep at channel 0.
- R4: With autoscan off, every conversion uses the 4-bit channel last written to address 1.
- R5: The trigger source is chosen as follows. Mode bit 2 selects the external strobe ahead of the others. Otherwise mode bit 1 selects the pacer strobe. Otherwise any write to address 5 is the trigger. Strobes from the sources not selected have no effect. An accepted trigger gives exactly one request pulse, in the cycle after it.
- R6: While a conversion is outstanding (from the request until done), status bit 7 reads 0 and any further trigger is ignored.
- R7: Address 2 accepts range codes 0 to 4 and ignores codes 5 to 7. The range drives the converter and reads back in status bits 2..0.
- R8: The FIFO returns samples in arrival order on reads of address 0, and each read removes one sample. Status bit 5 reads 0 once 512 or more entries are held. Status bit 6 reads 0 at 1024 entries. A sample that arrives while the FIFO is full is discarded. Status bit 4 reads 0 when the FIFO is empty.
- R9: Setting bit 2 of the interrupt-control register (address 4) empties the FIFO, and samples that arrive while the bit is set are dropped. Clearing the bit leaves the FIFO empty and accepting samples.
- R10: Bit 0 of address 4 selects what sets interrupt request 0. With the bit at 0, every completed conversion sets it. With the bit at 1, it is set only when the FIFO fill reaches 512.
- R11: Bit 1 of address 4 selects what sets interrupt request 1. With the bit at 0, a pacer strobe sets it. With the bit at 1, an external strobe sets it. This holds whatever the trigger source is.
- R12: Any write to address 6 drops both interrupt requests, even when a set condition occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (a read of address 0 removes one FIFO sample) |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 16 | Read data, valid in the same cycle as host_rd |
| pacer_tick | input | 1 | Pacer strobe |
| ext_trig | input | 1 | External trigger strobe |
| adc_req | output | 1 | One-cycle conversion request |
| adc_ch | output | 4 | Channel for the current conversion |
| adc_range | output | 3 | Input range code |
| adc_done | input | 1 | Conversion complete strobe |
| adc_sample | input | 16 | Conversion result, valid with adc_done |
| irq0 | output | 1 | Interrupt request 0 |
| irq1 | output | 1 | Interrupt request 1 |

## Verification
The hardest state to reach is the full FIFO, together with the sample that arrives after it fills. Reaching it takes more than a thousand complete trigger/done round trips. The bench runs that many software-triggered conversions, each with a distinct value. Along the way it watches the half-full flag and the half-full interrupt at the 511th and 512th entries. It then offers one extra sample and drains all 1024 entries in order. The extra sample is shown to be discarded because the FIFO reads empty right after the last expected value.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [2:0] {
        A_FIFO   = 3'd0,
        A_CHAN   = 3'd1,
        A_RANGE  = 3'd2,
        A_MODE   = 3'd3,
        A_ICTL   = 3'd4,
        A_SWTRIG = 3'd5,
        A_ICLR   = 3'd6
    } reg_addr_e;

    // bit order is decoded by software: [3] pretrig [2] ext [1] pacer [0] autoscan
    typedef struct packed {
        logic pretrig;
        logic ext_sel;
        logic pacer_sel;
        logic autoscan;
    } mode_t;

    // [2] fifo off, [1] irq1 cause ext, [0] irq0 cause half-full
    typedef struct packed {
        logic fifo_off;
        logic irq1_ext;
        logic irq0_half;
    } ictl_t;

    typedef enum logic [1:0] {SRC_SW, SRC_PACER, SRC_EXT} trig_src_e;

    localparam int MAX_RANGE_CODE = 4;

    function automatic trig_src_e pick_src(mode_t m);
        if (m.ext_sel)   return SRC_EXT;
        if (m.pacer_sel) return SRC_PACER;
        return SRC_SW;
    endfunction

endpackage

// File: rtl/acq_trig_seq.sv
module acq_trig_seq
    import acq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  trig_src_e        src,
    input  logic             autoscan,
    input  logic [CH_W-1:0]  chan_cfg,
    input  logic             restart,
    input  logic             sw_strobe,
    input  logic             pacer_tick,
    input  logic             ext_trig,
    input  logic             adc_done,
    output logic             adc_req,
    output logic [CH_W-1:0]  adc_ch,
    output logic             busy
);
    logic            trig_in;
    logic            fire;
    logic [CH_W-1:0] scan_idx;

    always_comb begin
        case (src)
            SRC_EXT:   trig_in = ext_trig;
            SRC_PACER: trig_in = pacer_tick;
            default:   trig_in = sw_strobe;
        endcase
    end

    assign fire = trig_in && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            adc_req <= 1'b0;
            adc_ch  <= '0;
        end else begin
            adc_req <= fire;
            if (fire) begin
                busy   <= 1'b1;
                adc_ch <= autoscan ? scan_idx : chan_cfg;
            end else if (adc_done) begin
                busy <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            scan_idx <= '0;
        end else if (fire && autoscan) begin
            scan_idx <= (scan_idx >= chan_cfg) ? '0 : scan_idx + 1'b1;
        end
    end

    assert_req_busy_R5: assert property (@(posedge clk) disable iff (rst)
        adc_req |-> busy);
    assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !adc_done) |=> (busy && !adc_req));

endmodule

// File: rtl/acq_sample_fifo.sv
module acq_sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 1024
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         half,
    output logic         full,
    output logic         half_hit
);
    localparam int AW   = $clog2(DEPTH);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty    = (cnt == '0);
    assign full     = (cnt == CW'(DEPTH));
    assign half     = (cnt >= CW'(HALF));
    assign do_push  = enable && push && !full;
    assign do_pop   = enable && pop && !empty;
    assign half_hit = do_push && !do_pop && (cnt == CW'(HALF - 1));
    assign dout     = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));
    assert_full_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (full && enable && !pop) |=> full);
    assert_flush_R9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> empty);

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int CH_W       = 4,
    parameter int RANGE_W    = 3,
    parameter int SAMPLE_W   = 16,
    parameter int FIFO_DEPTH = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [2:0]          host_addr,
    input  logic [7:0]          host_wdata,
    output logic [SAMPLE_W-1:0] host_rdata,
    input  logic                pacer_tick,
    input  logic                ext_trig,
    output logic                adc_req,
    output logic [CH_W-1:0]     adc_ch,
    output logic [RANGE_W-1:0]  adc_range,
    input  logic                adc_done,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic                irq0,
    output logic                irq1
);
    reg_addr_e           addr;
    mode_t               mode_q;
    ictl_t               ictl_q;
    logic [CH_W-1:0]     chan_q;
    logic [RANGE_W-1:0]  range_q;
    logic                busy, restart, sw_strobe, irq_clr;
    logic                f_empty, f_half, f_full, f_hit, f_pop;
    logic [SAMPLE_W-1:0] f_dout;
    logic                set0, set1;
    logic [7:0]          status_b;

    assign addr      = reg_addr_e'(host_addr);
    assign restart   = host_wr && (addr == A_CHAN || addr == A_MODE);
    assign sw_strobe = host_wr && (addr == A_SWTRIG);
    assign irq_clr   = host_wr && (addr == A_ICLR);
    assign f_pop     = host_rd && (addr == A_FIFO);
    assign adc_range = range_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            ictl_q  <= '0;
            chan_q  <= '0;
            range_q <= '0;
        end else if (host_wr) begin
            case (addr)
                A_CHAN:  chan_q <= host_wdata[CH_W-1:0];
                A_MODE:  mode_q <= mode_t'(host_wdata[3:0]);
                A_ICTL:  ictl_q <= ictl_t'(host_wdata[2:0]);
                A_RANGE: if (host_wdata[RANGE_W-1:0] <= RANGE_W'(MAX_RANGE_CODE))
                             range_q <= host_wdata[RANGE_W-1:0];
                default: ;
            endcase
        end
    end

    acq_trig_seq #(.CH_W(CH_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .src        (pick_src(mode_q)),
        .autoscan   (mode_q.autoscan),
        .chan_cfg   (chan_q),
        .restart    (restart),
        .sw_strobe  (sw_strobe),
        .pacer_tick (pacer_tick),
        .ext_trig   (ext_trig),
        .adc_done   (adc_done),
        .adc_req    (adc_req),
        .adc_ch     (adc_ch),
        .busy       (busy)
    );

    acq_sample_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .enable   (!ictl_q.fifo_off),
        .push     (adc_done),
        .din      (adc_sample),
        .pop      (f_pop),
        .dout     (f_dout),
        .empty    (f_empty),
        .half     (f_half),
        .full     (f_full),
        .half_hit (f_hit)
    );

    assign set0 = ictl_q.irq0_half ? f_hit : adc_done;
    assign set1 = ictl_q.irq1_ext ? ext_trig : pacer_tick;

    always_ff @(posedge clk) begin
        if (rst || irq_clr) begin
            irq0 <= 1'b0;
            irq1 <= 1'b0;
        end else begin
            irq0 <= irq0 | set0;
            irq1 <= irq1 | set1;
        end
    end

    always_comb begin
        status_b              = '0;
        status_b[7]           = !busy;
        status_b[6]           = !f_full;
        status_b[5]           = !f_half;
        status_b[4]           = !f_empty;
        status_b[RANGE_W-1:0] = range_q;
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            case (addr)
                A_FIFO:  host_rdata = f_empty ? '0 : f_dout;
                A_CHAN:  host_rdata[CH_W-1:0] = chan_q;
                A_RANGE: host_rdata[7:0] = status_b;
                A_MODE:  host_rdata[3:0] = mode_q;
                A_ICTL:  host_rdata[2:0] = ictl_q;
                default: ;
            endcase
        end
    end

    assert_irq_clear_R12: assert property (@(posedge clk) disable iff (rst)
        irq_clr |=> (!irq0 && !irq1));
    assert_range_legal_R7: assert property (@(posedge clk) disable iff (rst)
        range_q <= RANGE_W'(MAX_RANGE_CODE));

endmodule

// File: tb/acq_sequencer_bench.sv
module acq_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [15:0] host_rdata;
    logic        pacer_tick = 1'b0, ext_trig = 1'b0;
    logic        adc_req;
    logic [3:0]  adc_ch;
    logic [2:0]  adc_range;
    logic        adc_done = 1'b0;
    logic [15:0] adc_sample = '0;
    logic        irq0, irq1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    acq_sequencer u_acq_sequencer (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pacer_tick(pacer_tick), .ext_trig(ext_trig), .adc_req(adc_req),
        .adc_ch(adc_ch), .adc_range(adc_range), .adc_done(adc_done),
        .adc_sample(adc_sample), .irq0(irq0), .irq1(irq1)
    );

    // {mode[3:0], chan[3:0], expected channel of conversions 0..3}
    localparam logic [23:0] VEC [6] = '{
        24'h05_5555, 24'h12_0120, 24'h33_0123,
        24'h49_9999, 24'h50_0000, 24'h71_0101
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] q);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 q = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    // kind 0 software write, 1 pacer strobe, 2 external strobe
    task automatic pulse(input int kind);
        if (kind == 0) wr(3'd5, 8'h00);
        else begin
            @(negedge clk);
            if (kind == 1) pacer_tick = 1'b1; else ext_trig = 1'b1;
            @(negedge clk);
            pacer_tick = 1'b0; ext_trig = 1'b0;
        end
    endtask

    task automatic finish_conv(input logic [15:0] s);
        @(negedge clk);
        adc_done = 1'b1; adc_sample = s;
        @(negedge clk);
        adc_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] q;
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd2, q); chk("R1 status", q, 16'h00E0);
        rd(3'd3, q); chk("R1 mode", q, 16'h0000);
        chk("R1 irq/req", {irq0, irq1, adc_req}, 3'b000);

        // table walk: channel sequencing and source selection
        for (int i = 0; i < 6; i++) begin
            logic [3:0] m;
            int kind, wrong;
            m = VEC[i][23:20];
            kind  = m[2] ? 2 : (m[1] ? 1 : 0);
            wrong = (kind == 1) ? 0 : 1;
            wr(3'd3, {4'h0, m});
            wr(3'd1, {4'h0, VEC[i][19:16]});
            for (int j = 0; j < 4; j++) begin
                pulse(wrong);
                chk("R5 unselected source ignored", adc_req, 1'b0);
                pulse(kind);
                chk("R5 request pulse", adc_req, 1'b1);
                if (m[0]) chk("R3 autoscan channel", adc_ch, VEC[i][15-4*j -: 4]);
                else      chk("R4 fixed channel", adc_ch, VEC[i][15-4*j -: 4]);
                @(negedge clk);
                chk("R5 single pulse", adc_req, 1'b0);
                finish_conv({8'(i), 8'(j)});
            end
        end
        wr(3'd3, 8'h00);

        // R8 order of stored samples
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 4; j++) begin
                rd(3'd0, q); chk("R8 fifo order", q, {8'(i), 8'(j)});
            end
        rd(3'd2, q); chk("R8 empty after drain", q[4], 1'b0);

        // R2 mode readback with pretrigger
        wr(3'd3, 8'hFA); rd(3'd3, q); chk("R2 mode readback", q, 16'h000A);
        wr(3'd3, 8'h00);

        // R7 range
        wr(3'd2, 8'h03); rd(3'd2, q); chk("R7 range readback", q[2:0], 3'd3);
        chk("R7 range pin", adc_range, 3'd3);
        wr(3'd2, 8'h06); rd(3'd2, q); chk("R7 illegal range ignored", q[2:0], 3'd3);
        wr(3'd2, 8'h04); chk("R7 range 4 accepted", adc_range, 3'd4);
        wr(3'd2, 8'h00);

        // R6 busy
        pulse(0);
        rd(3'd2, q); chk("R6 busy flag low", q[7], 1'b0);
        pulse(0); chk("R6 trigger while busy ignored", adc_req, 1'b0);
        finish_conv(16'hBEEF);
        rd(3'd2, q); chk("R6 busy flag released", q[7], 1'b1);
        rd(3'd0, q); chk("R6 only one sample", q, 16'hBEEF);
        rd(3'd2, q); chk("R6 fifo empty after single sample", q[4], 1'b0);

        // R10 irq0 causes
        wr(3'd6, 8'h00); chk("R12 clear", {irq0, irq1}, 2'b00);
        pulse(0); finish_conv(16'h0001);
        chk("R10 end-of-conversion irq", irq0, 1'b1);
        wr(3'd6, 8'h00); chk("R12 clear irq0", irq0, 1'b0);
        wr(3'd4, 8'h01);
        pulse(0); finish_conv(16'h0002);
        chk("R10 half cause ignores single conversion", irq0, 1'b0);

        // R11 irq1 causes
        pulse(2); chk("R11 ext ignored for pacer cause", irq1, 1'b0);
        pulse(1); chk("R11 pacer sets irq1", irq1, 1'b1);
        wr(3'd4, 8'h03); wr(3'd6, 8'h00);
        pulse(1); chk("R11 pacer ignored for ext cause", irq1, 1'b0);
        pulse(2); chk("R11 ext sets irq1", irq1, 1'b1);

        // R12 clear wins over same-cycle set
        wr(3'd4, 8'h01); wr(3'd6, 8'h00);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 3'd6; host_wdata = 8'h00; pacer_tick = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; pacer_tick = 1'b0;
        chk("R12 clear beats set", irq1, 1'b0);

        // R9 flush and drop while disabled
        rd(3'd2, q); chk("R9 fifo holds samples before flush", q[4], 1'b1);
        wr(3'd4, 8'h05);
        rd(3'd2, q); chk("R9 disabled fifo empty", q[4], 1'b0);
        pulse(0); finish_conv(16'h7777);
        wr(3'd4, 8'h01);
        rd(3'd2, q); chk("R9 re-enabled fifo empty", q[4], 1'b0);

        // R8/R10 fill to half and full
        wr(3'd6, 8'h00);
        for (int k = 0; k < 1024; k++) begin
            pulse(0); finish_conv(16'(k));
            if (k == 510) begin
                rd(3'd2, q); chk("R8 not half at 511", q[5], 1'b1);
                chk("R10 no irq before half", irq0, 1'b0);
            end
            if (k == 511) begin
                rd(3'd2, q); chk("R8 half at 512", q[5], 1'b0);
                chk("R10 half-full irq", irq0, 1'b1);
            end
            if (k == 1022) begin
                rd(3'd2, q); chk("R8 not full at 1023", q[6], 1'b1);
            end
        end
        rd(3'd2, q); chk("R8 full at 1024", q[6], 1'b0);
        pulse(0); finish_conv(16'hFFFF);
        rd(3'd2, q); chk("R8 full holds on overflow", q[6], 1'b0);
        bad = 0;
        for (int k = 0; k < 1024; k++) begin
            rd(3'd0, q);
            if (q !== 16'(k)) bad++;
        end
        chk("R8 drained values in order", bad, 0);
        rd(3'd2, q); chk("R8 overflow sample discarded", q[4], 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule